// File: doc/BRIEF.md
# Double-Buffered Receive Endpoint Buffer with DMA Release

This block sits between the packet receive logic of a bulk-OUT style endpoint and the consumer of its data, either a DMA engine or a CPU. Two packet buffers, each `DEPTH` bytes deep, are filled one after the other from a byte-wide write port. A packet ends with an end-of-packet flag or when a buffer becomes full, whichever happens first. Each buffer keeps the length of its packet. The consumer reads bytes in order through a read port whose `rd_empty_o` output marks the end of the current packet.

A buffer stays owned by the reader until it is released. With DMA mode off, software releases the drained buffer with a one-cycle pulse, and only then does the next buffer become readable. With DMA mode on, the block releases the selected buffer itself as soon as that buffer runs out of data, for full and short packets alike. In that mode an active-low request line, chosen by a select input, is pulled low while any buffer holds a packet. A software release in DMA mode would cause an excess transfer. The block therefore ignores it and raises a sticky error flag.

While both buffers hold unread packets, the write side sees a busy indication and its bytes are discarded. This is the cue for the upstream protocol logic to answer with a NAK.

Top module: `rx_ep_dbuf_dma`

## Requirements
- R1: After reset, both request lines are high, `rd_empty_o` is 1, `wr_busy_o` is 0 and `sw_err_o` is 0.
- R2: A write with `wr_last_i`=1 closes a packet of N bytes (1..DEPTH). The DEPTH-th byte closes the packet even without `wr_last_i`. The read port then presents the N bytes in write order, one per accepted `rd_en_i`, and `rd_empty_o` rises after the N-th byte.
- R3: Packets are stored alternately in the two buffers and read back in arrival order.
- R4: `wr_busy_o` is 1 exactly while both buffers hold unreleased packets. Writes during busy are discarded and create no packet.
- R5: With `dma_en_i`=1, the selected request line is low while at least one buffer holds a packet. It returns high only once both buffers are released.
- R6: `req_sel_i`=0 drives `dreq_no[0]` and `req_sel_i`=1 drives `dreq_no[1]`. The other line stays high, and both lines are high while `dma_en_i`=0.
- R7: In DMA mode, reading the last byte of the selected buffer releases it in the same clock edge and switches to the other buffer, for full and short packets. A 64+64+22 byte sequence causes three releases and leaves both lines high.
- R8: With DMA mode off, a drained buffer stays selected (`rd_empty_o`=1) until a `sw_rd_done_i` pulse releases it. The next packet becomes readable after that pulse.
- R9: A `sw_rd_done_i` pulse in DMA mode releases nothing and sets `sw_err_o`, which stays 1 until reset. The same pulse with DMA mode off never sets it.
- R10: Enabling DMA mode while the selected buffer is already drained but unreleased releases that buffer on the next edge.
- R11: `rd_en_i` while `rd_empty_o`=1 has no effect on data or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte strobe from packet side |
| wr_data_i | input | DATA_W | Write byte |
| wr_last_i | input | 1 | Byte is the final byte of its packet |
| wr_busy_o | output | 1 | Both buffers occupied, write refused |
| rd_en_i | input | 1 | Consume the presented byte |
| rd_data_o | output | DATA_W | Byte at the read pointer of the selected buffer |
| rd_empty_o | output | 1 | No unread byte in the selected buffer |
| dma_en_i | input | 1 | DMA mode enable |
| req_sel_i | input | 1 | Selects which request line is used |
| dreq_no | output | 2 | Active-low DMA request lines |
| sw_rd_done_i | input | 1 | Software release pulse |
| sw_err_o | output | 1 | Sticky: software release seen in DMA mode |

## Verification
A wrong buffer-ownership state shows at the ports within one cycle of its cause. A buffer released too early or twice either raises the request line while a packet is still pending or drops `wr_busy_o` while a packet is unread. A missing automatic release leaves `rd_empty_o` high with the request line still low. A wrong read pointer or buffer select appears on the very next compared byte, because every byte pushed by the writer must come back from the read port in the same order. A discarded write that slipped through shows up as an extra readable packet once both real packets are released.

// File: rtl/rx_ep_pkg.sv
package rx_ep_pkg;
  typedef enum logic {
    BUF_A = 1'b0,
    BUF_B = 1'b1
  } buf_id_t;

  function automatic buf_id_t other_buf(buf_id_t b);
    return (b == BUF_A) ? BUF_B : BUF_A;
  endfunction
endpackage

// File: rtl/rx_ep_buf_bank.sv
module rx_ep_buf_bank
  import rx_ep_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  buf_id_t                wr_sel_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic                   close_i,
  input  logic [LW-1:0]          close_len_i,
  input  logic [1:0]             clr_i,
  input  buf_id_t                rd_sel_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [1:0]             full_o,
  output logic [1:0][LW-1:0]     len_o
);
  logic [DATA_W-1:0] rd_word [2];

  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic [DATA_W-1:0] mem [DEPTH];
    logic              full_q;
    logic [LW-1:0]     len_q;
    logic              sel_wr;

    assign sel_wr = (wr_sel_i == buf_id_t'(g));

    always_ff @(posedge clk_i) begin
      if (wr_en_i && sel_wr) mem[wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q <= 1'b0;
        len_q  <= '0;
      end else if (close_i && sel_wr) begin
        full_q <= 1'b1;
        len_q  <= close_len_i;
      end else if (clr_i[g]) begin
        full_q <= 1'b0;
      end
    end

    assign rd_word[g] = mem[rd_addr_i];
    assign full_o[g]  = full_q;
    assign len_o[g]   = len_q;
  end

  assign rd_data_o = rd_word[rd_sel_i];
endmodule

// File: rtl/rx_ep_wr_ctrl.sv
module rx_ep_wr_ctrl
  import rx_ep_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          wr_last_i,
  input  logic [1:0]    full_i,
  output logic          accept_o,
  output buf_id_t       sel_o,
  output logic [AW-1:0] addr_o,
  output logic          close_o,
  output logic [LW-1:0] close_len_o,
  output logic          busy_o
);
  buf_id_t       sel_q;
  logic [AW-1:0] cnt_q;

  // writer fills in order, so its target is only occupied when both are
  assign busy_o      = full_i[sel_q];
  assign accept_o    = wr_valid_i && !busy_o;
  assign close_o     = accept_o && (wr_last_i || cnt_q == AW'(DEPTH - 1));
  assign close_len_o = LW'(cnt_q) + LW'(1);
  assign sel_o       = sel_q;
  assign addr_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= BUF_A;
      cnt_q <= '0;
    end else if (close_o) begin
      sel_q <= other_buf(sel_q);
      cnt_q <= '0;
    end else if (accept_o) begin
      cnt_q <= cnt_q + AW'(1);
    end
  end
endmodule

// File: rtl/rx_ep_rd_ctrl.sv
module rx_ep_rd_ctrl
  import rx_ep_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             dma_en_i,
  input  logic             sw_done_i,
  input  logic [1:0]       full_i,
  input  logic [1:0][LW-1:0] len_i,
  output buf_id_t          sel_o,
  output logic [AW-1:0]    addr_o,
  output logic             empty_o,
  output logic [1:0]       clr_o,
  output logic             err_o
);
  buf_id_t       sel_q;
  logic [LW-1:0] cnt_q;
  logic          err_q;
  logic          cur_full, avail, fire, last_rd, drained;
  logic          auto_rel, sw_rel, release_w;
  logic [LW-1:0] cur_len;

  assign cur_full = full_i[sel_q];
  assign cur_len  = len_i[sel_q];
  assign avail    = cur_full && (cnt_q < cur_len);
  assign fire     = rd_en_i && avail;
  assign last_rd  = fire && (cnt_q == cur_len - LW'(1));
  assign drained  = cur_full && (cnt_q == cur_len);

  // DMA mode frees the buffer on its final read, or at once if already drained
  assign auto_rel  = dma_en_i && (last_rd || drained);
  assign sw_rel    = sw_done_i && !dma_en_i && cur_full;
  assign release_w = auto_rel || sw_rel;

  always_comb begin
    clr_o = 2'b00;
    clr_o[sel_q] = release_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= BUF_A;
      cnt_q <= '0;
    end else if (release_w) begin
      sel_q <= other_buf(sel_q);
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= cnt_q + LW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= 1'b0;
    else if (sw_done_i && dma_en_i)  err_q <= 1'b1;
  end

  assign sel_o   = sel_q;
  assign addr_o  = cnt_q[AW-1:0];
  assign empty_o = !avail;
  assign err_o   = err_q;
endmodule

// File: rtl/rx_ep_dbuf_dma.sv
module rx_ep_dbuf_dma
  import rx_ep_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  output logic              wr_busy_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_empty_o,
  input  logic              dma_en_i,
  input  logic              req_sel_i,
  output logic [1:0]        dreq_no,
  input  logic              sw_rd_done_i,
  output logic              sw_err_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam int unsigned NREQ = 2;

  logic              wr_accept, wr_close;
  buf_id_t           wr_sel, rd_sel;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [LW-1:0]     wr_len;
  logic [1:0]        buf_full, buf_clr;
  logic [1:0][LW-1:0] buf_len;
  logic              req_active;

  rx_ep_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_last_i   (wr_last_i),
    .full_i      (buf_full),
    .accept_o    (wr_accept),
    .sel_o       (wr_sel),
    .addr_o      (wr_addr),
    .close_o     (wr_close),
    .close_len_o (wr_len),
    .busy_o      (wr_busy_o)
  );

  rx_ep_buf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_accept),
    .wr_sel_i    (wr_sel),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data_i),
    .close_i     (wr_close),
    .close_len_i (wr_len),
    .clr_i       (buf_clr),
    .rd_sel_i    (rd_sel),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data_o),
    .full_o      (buf_full),
    .len_o       (buf_len)
  );

  rx_ep_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .dma_en_i  (dma_en_i),
    .sw_done_i (sw_rd_done_i),
    .full_i    (buf_full),
    .len_i     (buf_len),
    .sel_o     (rd_sel),
    .addr_o    (rd_addr),
    .empty_o   (rd_empty_o),
    .clr_o     (buf_clr),
    .err_o     (sw_err_o)
  );

  assign req_active = dma_en_i && (|buf_full);

  for (genvar r = 0; r < NREQ; r++) begin : g_req
    assign dreq_no[r] = !(req_active && (req_sel_i == 1'(r)));
  end
endmodule

// File: rtl/rx_ep_chk.sv
module rx_ep_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_busy_o,
  input logic       rd_empty_o,
  input logic       dma_en_i,
  input logic       sw_rd_done_i,
  input logic       sw_err_o,
  input logic [1:0] dreq_no,
  input logic [1:0] buf_full,
  input logic       rd_sel
);
  AST_BUSY_BOTH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_o |-> (buf_full == 2'b11)); // R4
  AST_DREQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> (dreq_no == 2'b11)); // R6
  AST_DREQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~dreq_no) <= 1); // R6
  AST_DREQ_HIGH_NO_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_full == 2'b00) |-> (dreq_no == 2'b11)); // R5
  AST_READ_NEEDS_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_empty_o |-> buf_full[rd_sel]); // R2
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rd_done_i && dma_en_i) |=> sw_err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_err_o |=> sw_err_o); // R9
endmodule

bind rx_ep_dbuf_dma rx_ep_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_busy_o    (wr_busy_o),
  .rd_empty_o   (rd_empty_o),
  .dma_en_i     (dma_en_i),
  .sw_rd_done_i (sw_rd_done_i),
  .sw_err_o     (sw_err_o),
  .dreq_no      (dreq_no),
  .buf_full     (buf_full),
  .rd_sel       (rd_sel)
);

// File: tb/rx_ep_dbuf_dma_tb.sv
module rx_ep_dbuf_dma_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_last = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       dma_en = 1'b0, req_sel = 1'b0, sw_done = 1'b0;
  logic       wr_busy, rd_empty, sw_err;
  logic [7:0] rd_data;
  logic [1:0] dreq_n;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  rx_ep_dbuf_dma u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_last_i(wr_last),
    .wr_busy_o(wr_busy),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_empty_o(rd_empty),
    .dma_en_i(dma_en), .req_sel_i(req_sel), .dreq_no(dreq_n),
    .sw_rd_done_i(sw_done), .sw_err_o(sw_err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: writes a packet and pushes the expected bytes
  task automatic send_pkt(int len, logic [7:0] base, bit use_last);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = base + 8'(i);
      wr_last  = use_last && (i == len - 1);
      exp_q.push_back(base + 8'(i));
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  // monitor side: pops expected bytes and compares against the read port
  task automatic read_n(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, int'(rd_empty), 0);
      if (exp_q.size() > 0) chk(req, int'(rd_data), int'(exp_q.pop_front()));
      else chk(req, exp_q.size(), 1);
      rd_en = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk);
    sw_done = 1'b1;
    @(negedge clk);
    sw_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(dreq_n), 3);
    chk("R1", int'(rd_empty), 1);
    chk("R1", int'(wr_busy), 0);
    chk("R1", int'(sw_err), 0);

    // software release mode
    send_pkt(5, 8'h10, 1'b1);
    chk("R2", int'(rd_empty), 0);
    chk("R6", int'(dreq_n), 3);
    read_n(5, "R2");
    chk("R2", int'(rd_empty), 1);
    send_pkt(64, 8'h40, 1'b0);          // closes on the 64th byte
    chk("R4", int'(wr_busy), 1);
    chk("R8", int'(rd_empty), 1);
    @(negedge clk);                      // refused write
    wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    @(negedge clk);                      // read while empty
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11", int'(rd_empty), 1);
    pulse_sw();
    chk("R8", int'(rd_empty), 0);
    chk("R4", int'(wr_busy), 0);
    chk("R9", int'(sw_err), 0);
    read_n(64, "R3");
    chk("R8", int'(rd_empty), 1);
    pulse_sw();
    chk("R4", int'(rd_empty), 1);       // refused byte formed no packet

    // DMA mode, 150 bytes as 64 + 64 + 22
    @(negedge clk);
    dma_en = 1'b1; req_sel = 1'b0;
    @(negedge clk);
    chk("R5", int'(dreq_n), 3);
    send_pkt(64, 8'h00, 1'b1);
    send_pkt(64, 8'h80, 1'b0);
    chk("R4", int'(wr_busy), 1);
    chk("R6", int'(dreq_n), 2);
    read_n(64, "R7");
    chk("R5", int'(dreq_n), 2);
    chk("R7", int'(wr_busy), 0);
    send_pkt(22, 8'hC0, 1'b1);
    read_n(64, "R7");
    chk("R5", int'(dreq_n), 2);
    read_n(22, "R7");
    chk("R7", int'(dreq_n), 3);
    chk("R7", int'(rd_empty), 1);
    chk("R7", int'(wr_busy), 0);
    chk("R3", exp_q.size(), 0);

    // other request line, software release in DMA mode
    @(negedge clk);
    req_sel = 1'b1;
    send_pkt(3, 8'h30, 1'b1);
    chk("R6", int'(dreq_n), 1);
    pulse_sw();
    chk("R9", int'(sw_err), 1);
    chk("R9", int'(rd_empty), 0);
    chk("R9", int'(rd_data), 8'h30);
    read_n(3, "R9");
    chk("R5", int'(dreq_n), 3);

    // DMA enabled over a drained, unreleased buffer
    @(negedge clk);
    dma_en = 1'b0;
    send_pkt(4, 8'h50, 1'b1);
    chk("R6", int'(dreq_n), 3);
    read_n(4, "R10");
    chk("R10", int'(rd_empty), 1);
    dma_en = 1'b1;
    @(negedge clk);
    chk("R10", int'(dreq_n), 3);
    chk("R10", int'(rd_empty), 1);
    chk("R10", int'(wr_busy), 0);
    chk("R9", int'(sw_err), 1);

    finish_run();
  end
endmodule